// File: doc/BRIEF.md
# Retire Timing Tracker

This block sits beside the retire stage of an in-order pipeline and accounts for the time each retiring instruction costs. An instruction is presented on a single cycle with a valid strobe. The presentation carries the instruction's class, its base cycle cost, two optional source operands, a destination index, a taken flag and a delay-slot flag. The block adds load-use penalties and control-transfer penalties to the base cost. It presents the resulting per-instruction count and accumulates running totals.

Load-use hazards are tracked with two 16-bit register masks. While an instruction is being accounted, a pending mask collects the destination of a load. When the instruction completes, that pending mask becomes the active mask. The stall check always consults the active mask. As a result, a load can only penalise the next presented instruction that reads its destination, and any other intervening instruction clears the hazard.

Top module: `retire_timing_tracker`

## Requirements
- R1: A synchronous active-high reset clears every counter, the current-instruction output and both register masks. An instruction right after reset sees no load stall.
- R2: A load marks its destination register. Only the next valid instruction sees that mark. Cycles without the valid strobe neither clear nor move it, and any valid instruction that is not a load leaves no mark behind.
- R3: A load checks only operand B, its base-address source, for a stall. Operand A is ignored for loads.
- R4: ALU (class 0) and store (class 2) instructions check both operands. Each checked operand whose register is marked adds one cycle and adds one to the load-stall counter. Equal marked operands therefore add two.
- R5: An operand whose valid bit is low never causes a stall, whatever its index.
- R6: A control transfer (class 3) checks operand A only. When it is taken and has no delay slot, it adds one cycle and increments the control-stall counter. Each taken transfer increments the taken counter, and each untaken one increments the untaken counter. The taken and delay-slot flags are ignored for all other classes.
- R7: Load-multiple (class 4), store-multiple (class 5) and the unused codes 6 and 7 cost exactly their base count. They perform no stall check and leave no mark.
- R8: The final count of an instruction, meaning base plus load stalls plus the control penalty, appears on the current-cycle output on the clock after its strobe. The same value is added to the running total at that clock. The class encoding is 0 ALU, 1 load, 2 store, 3 control transfer, 4 load-multiple, 5 store-multiple.
- R9: With the valid strobe low, all counters and the current-cycle output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | One instruction presented this cycle |
| ret_class | input | 3 | Instruction class code |
| ret_base | input | BASE_W | Base cycle cost |
| op_a_vld | input | 1 | Operand A present |
| op_a_idx | input | 4 | Operand A register index |
| op_b_vld | input | 1 | Operand B present |
| op_b_idx | input | 4 | Operand B register index |
| dst_idx | input | 4 | Load destination register index |
| ret_taken | input | 1 | Control transfer taken |
| ret_dslot | input | 1 | Control transfer has a delay slot |
| cur_cycles | output | CNT_W | Final count of the last instruction |
| total_cycles | output | CNT_W | Running cycle total |
| load_stalls | output | CNT_W | Load-use stall cycles |
| cti_stalls | output | CNT_W | Control-transfer stall cycles |
| taken_count | output | CNT_W | Taken control transfers |
| untaken_count | output | CNT_W | Untaken control transfers |

## Verification
A control transfer can suffer a load-use stall on operand A and the no-delay-slot taken penalty in the same instruction. The bench provokes this by issuing a load to some register and then, back to back, a taken transfer without a delay slot that reads that register. The judgement is that the count rises by exactly two, and that the load-stall and control-stall counters each step by one. The same overlap is reached many more times in a long pseudo-random stream that uses a small register range, with a behavioural model compared on every clock.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    localparam int REG_N     = 16;
    localparam int REG_IDX_W = $clog2(REG_N);
    localparam int N_SRC     = 2;

    typedef enum logic [2:0] {
        CLS_ALU   = 3'd0,
        CLS_LOAD  = 3'd1,
        CLS_STORE = 3'd2,
        CLS_CTI   = 3'd3,
        CLS_LDM   = 3'd4,
        CLS_STM   = 3'd5
    } ins_class_e;

    // counter slots inside the counter bank
    localparam int CI_TOTAL   = 0;
    localparam int CI_LDSTALL = 1;
    localparam int CI_CTSTALL = 2;
    localparam int CI_TAKEN   = 3;
    localparam int CI_UNTAKEN = 4;
    localparam int NUM_CNT    = 5;

    typedef struct packed {
        logic                 vld;
        logic [REG_IDX_W-1:0] idx;
    } opnd_t;

    typedef struct packed {
        logic chk_a;
        logic chk_b;
        logic is_load;
        logic is_cti;
    } class_ctl_t;

    function automatic class_ctl_t class_decode(input logic [2:0] cls);
        class_ctl_t c;
        c = '0;
        case (cls)
            CLS_ALU, CLS_STORE: begin
                c.chk_a = 1'b1;
                c.chk_b = 1'b1;
            end
            CLS_LOAD: begin
                c.chk_b   = 1'b1;
                c.is_load = 1'b1;
            end
            CLS_CTI: begin
                c.chk_a  = 1'b1;
                c.is_cti = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic [REG_N-1:0] reg_bit(input logic [REG_IDX_W-1:0] idx);
        logic [REG_N-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rtt_load_mask.sv
module rtt_load_mask
    import rtt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ins_fire,
    input  logic                 is_load,
    input  logic [REG_IDX_W-1:0] dst_idx,
    output logic [REG_N-1:0]     active_mask
);

    logic [REG_N-1:0] pending;

    // pending starts empty for each instruction; a load adds its destination
    always_comb begin
        pending = '0;
        if (is_load)
            pending = pending | reg_bit(dst_idx);
    end

    // on completion the pending set becomes the set seen by the next instruction
    always_ff @(posedge clk) begin
        if (rst)
            active_mask <= '0;
        else if (ins_fire)
            active_mask <= pending;
    end

endmodule

// File: rtl/rtt_stall_check.sv
module rtt_stall_check
    import rtt_pkg::*;
(
    input  logic [REG_N-1:0]     active_mask,
    input  opnd_t                opnd_a,
    input  opnd_t                opnd_b,
    input  logic                 chk_a,
    input  logic                 chk_b,
    output logic [1:0]           n_stall
);

    opnd_t            src [N_SRC];
    logic [N_SRC-1:0] chk;
    logic [N_SRC-1:0] hit;

    assign src[0] = opnd_a;
    assign src[1] = opnd_b;
    assign chk    = {chk_b, chk_a};

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = chk[g] & src[g].vld & active_mask[src[g].idx];
    end

    always_comb begin
        n_stall = '0;
        for (int i = 0; i < N_SRC; i++)
            n_stall = n_stall + {1'b0, hit[i]};
    end

endmodule

// File: rtl/rtt_cti_eval.sv
module rtt_cti_eval (
    input  logic is_cti,
    input  logic taken,
    input  logic dslot,
    output logic penalty,
    output logic taken_inc,
    output logic untaken_inc
);

    always_comb begin
        taken_inc   = is_cti & taken;
        untaken_inc = is_cti & ~taken;
        penalty     = is_cti & taken & ~dslot;
    end

endmodule

// File: rtl/rtt_counter_bank.sv
module rtt_counter_bank #(
    parameter int CNT_W = 32,
    parameter int N     = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N-1:0]              inc_en,
    input  logic [N-1:0][CNT_W-1:0]   inc_val,
    output logic [N-1:0][CNT_W-1:0]   cnt
);

    for (genvar g = 0; g < N; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                cnt[g] <= '0;
            else if (inc_en[g])
                cnt[g] <= cnt[g] + inc_val[g];
        end
    end

endmodule

// File: rtl/retire_timing_tracker.sv
module retire_timing_tracker
    import rtt_pkg::*;
#(
    parameter int BASE_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ret_valid,
    input  logic [2:0]           ret_class,
    input  logic [BASE_W-1:0]    ret_base,
    input  logic                 op_a_vld,
    input  logic [REG_IDX_W-1:0] op_a_idx,
    input  logic                 op_b_vld,
    input  logic [REG_IDX_W-1:0] op_b_idx,
    input  logic [REG_IDX_W-1:0] dst_idx,
    input  logic                 ret_taken,
    input  logic                 ret_dslot,
    output logic [CNT_W-1:0]     cur_cycles,
    output logic [CNT_W-1:0]     total_cycles,
    output logic [CNT_W-1:0]     load_stalls,
    output logic [CNT_W-1:0]     cti_stalls,
    output logic [CNT_W-1:0]     taken_count,
    output logic [CNT_W-1:0]     untaken_count
);

    class_ctl_t                   ctl;
    opnd_t                        opa, opb;
    logic [REG_N-1:0]             active_mask;
    logic [1:0]                   n_stall;
    logic                         cti_pen, tk_inc, untk_inc;
    logic [CNT_W-1:0]             cyc_final;
    logic [NUM_CNT-1:0]           inc_en;
    logic [NUM_CNT-1:0][CNT_W-1:0] inc_val;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

    assign ctl = class_decode(ret_class);
    assign opa = '{vld: op_a_vld, idx: op_a_idx};
    assign opb = '{vld: op_b_vld, idx: op_b_idx};

    rtt_load_mask u_mask (
        .clk         (clk),
        .rst         (rst),
        .ins_fire    (ret_valid),
        .is_load     (ctl.is_load),
        .dst_idx     (dst_idx),
        .active_mask (active_mask)
    );

    rtt_stall_check u_stall (
        .active_mask (active_mask),
        .opnd_a      (opa),
        .opnd_b      (opb),
        .chk_a       (ctl.chk_a),
        .chk_b       (ctl.chk_b),
        .n_stall     (n_stall)
    );

    rtt_cti_eval u_cti (
        .is_cti      (ctl.is_cti),
        .taken       (ret_taken),
        .dslot       (ret_dslot),
        .penalty     (cti_pen),
        .taken_inc   (tk_inc),
        .untaken_inc (untk_inc)
    );

    assign cyc_final = CNT_W'(ret_base) + CNT_W'(n_stall) + CNT_W'(cti_pen);

    always_comb begin
        inc_en              = '0;
        inc_val             = '0;
        inc_en[CI_TOTAL]    = ret_valid;
        inc_val[CI_TOTAL]   = cyc_final;
        inc_en[CI_LDSTALL]  = ret_valid & (n_stall != 2'd0);
        inc_val[CI_LDSTALL] = CNT_W'(n_stall);
        inc_en[CI_CTSTALL]  = ret_valid & cti_pen;
        inc_val[CI_CTSTALL] = CNT_W'(1);
        inc_en[CI_TAKEN]    = ret_valid & tk_inc;
        inc_val[CI_TAKEN]   = CNT_W'(1);
        inc_en[CI_UNTAKEN]  = ret_valid & untk_inc;
        inc_val[CI_UNTAKEN] = CNT_W'(1);
    end

    rtt_counter_bank #(.CNT_W(CNT_W), .N(NUM_CNT)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_en  (inc_en),
        .inc_val (inc_val),
        .cnt     (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cur_cycles <= '0;
        else if (ret_valid)
            cur_cycles <= cyc_final;
    end

    assign total_cycles  = cnt[CI_TOTAL];
    assign load_stalls   = cnt[CI_LDSTALL];
    assign cti_stalls    = cnt[CI_CTSTALL];
    assign taken_count   = cnt[CI_TAKEN];
    assign untaken_count = cnt[CI_UNTAKEN];

endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
    parameter int BASE_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ret_valid,
    input logic [2:0]        ret_class,
    input logic [BASE_W-1:0] ret_base,
    input logic              op_a_vld,
    input logic              op_b_vld,
    input logic [CNT_W-1:0]  cur_cycles,
    input logic [CNT_W-1:0]  total_cycles,
    input logic [CNT_W-1:0]  load_stalls,
    input logic [CNT_W-1:0]  cti_stalls,
    input logic [CNT_W-1:0]  taken_count,
    input logic [CNT_W-1:0]  untaken_count
);

    AST_TOTAL_ACCUM: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> total_cycles == $past(total_cycles) + cur_cycles); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ret_valid |=> $stable(total_cycles) && $stable(load_stalls) && $stable(cti_stalls)
                       && $stable(taken_count) && $stable(untaken_count) && $stable(cur_cycles)); // R9

    AST_BRANCH_ONE: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_class == 3'd3) |=>
            (taken_count + untaken_count) == $past(taken_count + untaken_count) + 1); // R6

    AST_NONCTI_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_class != 3'd3) |=>
            $stable(taken_count) && $stable(untaken_count) && $stable(cti_stalls)); // R6

    AST_MULTI_BASE: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_class >= 3'd4) |=>
            cur_cycles == CNT_W'($past(ret_base)) && $stable(load_stalls)); // R7

    AST_ABSENT_NOSTALL: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !op_a_vld && !op_b_vld) |=> $stable(load_stalls)); // R5

    AST_CUR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> cur_cycles >= CNT_W'($past(ret_base))
                      && cur_cycles <= CNT_W'($past(ret_base)) + 3); // R8

endmodule

bind retire_timing_tracker rtt_checker #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ret_valid     (ret_valid),
    .ret_class     (ret_class),
    .ret_base      (ret_base),
    .op_a_vld      (op_a_vld),
    .op_b_vld      (op_b_vld),
    .cur_cycles    (cur_cycles),
    .total_cycles  (total_cycles),
    .load_stalls   (load_stalls),
    .cti_stalls    (cti_stalls),
    .taken_count   (taken_count),
    .untaken_count (untaken_count)
);

// File: tb/sim_retire_timing_tracker.sv
`timescale 1ns/1ps
module sim_retire_timing_tracker;

    localparam int BASE_W = 8;
    localparam int CNT_W  = 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             ret_valid;
    logic [2:0]       ret_class;
    logic [BASE_W-1:0] ret_base;
    logic             op_a_vld, op_b_vld;
    logic [3:0]       op_a_idx, op_b_idx, dst_idx;
    logic             ret_taken, ret_dslot;
    logic [CNT_W-1:0] cur_cycles, total_cycles, load_stalls, cti_stalls, taken_count, untaken_count;

    always #4 clk = ~clk;

    retire_timing_tracker #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_class(ret_class), .ret_base(ret_base),
        .op_a_vld(op_a_vld), .op_a_idx(op_a_idx), .op_b_vld(op_b_vld), .op_b_idx(op_b_idx),
        .dst_idx(dst_idx), .ret_taken(ret_taken), .ret_dslot(ret_dslot),
        .cur_cycles(cur_cycles), .total_cycles(total_cycles), .load_stalls(load_stalls),
        .cti_stalls(cti_stalls), .taken_count(taken_count), .untaken_count(untaken_count)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // behavioural reference state
    bit          m_mark [16];
    int unsigned m_cur, m_total, m_ld, m_ct, m_tk, m_utk;

    task automatic model_reset();
        foreach (m_mark[i]) m_mark[i] = 0;
        m_cur = 0; m_total = 0; m_ld = 0; m_ct = 0; m_tk = 0; m_utk = 0;
    endtask

    task automatic model_instr(input int cls, input int base, input bit av, input int ai,
                               input bit bv, input int bi, input int dst,
                               input bit tk, input bit ds);
        int st;
        int cyc;
        bit look_a, look_b;
        st = 0;
        look_a = (cls == 0 || cls == 2 || cls == 3);
        look_b = (cls == 0 || cls == 2 || cls == 1);
        if (look_a && av && m_mark[ai]) st++;
        if (look_b && bv && m_mark[bi]) st++;
        cyc = base + st;
        if (cls == 3) begin
            if (tk) begin
                m_tk++;
                if (!ds) begin cyc++; m_ct++; end
            end else begin
                m_utk++;
            end
        end
        m_ld    += st;
        m_total += cyc;
        m_cur    = cyc;
        foreach (m_mark[i]) m_mark[i] = 0;
        if (cls == 1) m_mark[dst] = 1;
    endtask

    task automatic chk1(input string tag, input string what, input logic [CNT_W-1:0] act,
                        input int unsigned exp);
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        n_checks++;
        chk1(tag, "cur_cycles",    cur_cycles,    m_cur);
        chk1(tag, "total_cycles",  total_cycles,  m_total);
        chk1(tag, "load_stalls",   load_stalls,   m_ld);
        chk1(tag, "cti_stalls",    cti_stalls,    m_ct);
        chk1(tag, "taken_count",   taken_count,   m_tk);
        chk1(tag, "untaken_count", untaken_count, m_utk);
    endtask

    // literal check of one expected count, independent of the model
    task automatic expect_cur(input string tag, input int unsigned exp);
        n_checks++;
        chk1(tag, "cur_cycles(literal)", cur_cycles, exp);
    endtask

    // called at a falling edge; returns at the next falling edge after comparing
    task automatic issue(input string tag, input int cls, input int base, input bit av, input int ai,
                         input bit bv, input int bi, input int dst, input bit tk, input bit ds);
        ret_valid = 1; ret_class = 3'(cls); ret_base = BASE_W'(base);
        op_a_vld = av; op_a_idx = 4'(ai); op_b_vld = bv; op_b_idx = 4'(bi);
        dst_idx = 4'(dst); ret_taken = tk; ret_dslot = ds;
        model_instr(cls, base, av, ai, bv, bi, dst, tk, ds);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        ret_valid = 0;
        ret_class = 3'($urandom_range(0, 7)); ret_base = BASE_W'($urandom);
        op_a_vld = 1; op_b_vld = 1; ret_taken = 1; ret_dslot = 0;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1; ret_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        compare(tag);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        rst = 1; ret_valid = 0; ret_class = 0; ret_base = 0;
        op_a_vld = 0; op_a_idx = 0; op_b_vld = 0; op_b_idx = 0;
        dst_idx = 0; ret_taken = 0; ret_dslot = 0;
        model_reset();
        @(negedge clk);
        do_reset("R1_reset_state");

        // R2: mark survives idle cycles, consumed by the next instruction
        issue("R2_load", 1, 2, 0, 0, 0, 0, 3, 0, 0);
        idle("R9_idle");
        idle("R9_idle");
        issue("R2_use_after_idle", 0, 1, 1, 3, 0, 0, 0, 0, 0);
        expect_cur("R2", 2);
        issue("R2_mark_cleared", 0, 1, 1, 3, 0, 0, 0, 0, 0);
        expect_cur("R2", 1);
        // R2: load to load chain
        issue("R2_load_a", 1, 1, 0, 0, 0, 0, 4, 0, 0);
        issue("R2_load_chain", 1, 1, 0, 0, 1, 4, 4, 0, 0);
        expect_cur("R2", 2);

        // R3: load ignores operand A
        issue("R3_load", 1, 1, 0, 0, 0, 0, 7, 0, 0);
        issue("R3_load_srcA", 1, 3, 1, 7, 1, 2, 8, 0, 0);
        expect_cur("R3", 3);

        // R4: store with both operands on the marked register
        issue("R4_load", 1, 1, 0, 0, 0, 0, 9, 0, 0);
        issue("R4_store_double", 2, 1, 1, 9, 1, 9, 0, 0, 0);
        expect_cur("R4", 3);
        issue("R4_load", 1, 1, 0, 0, 0, 0, 10, 0, 0);
        issue("R4_alu_b_only", 0, 4, 1, 11, 1, 10, 0, 1, 0);
        expect_cur("R4", 5);

        // R5: absent operands never stall
        issue("R5_load", 1, 1, 0, 0, 0, 0, 0, 0, 0);
        issue("R5_absent", 0, 2, 0, 0, 0, 0, 0, 0, 0);
        expect_cur("R5", 2);

        // R6: control-transfer combinations, including overlap with load stall
        issue("R6_load", 1, 1, 0, 0, 0, 0, 5, 0, 0);
        issue("R6_taken_nods_stall", 3, 1, 1, 5, 1, 5, 0, 1, 0);
        expect_cur("R6", 3);
        issue("R6_taken_ds", 3, 2, 1, 5, 0, 0, 0, 1, 1);
        expect_cur("R6", 2);
        issue("R6_untaken", 3, 2, 0, 0, 0, 0, 0, 0, 0);
        expect_cur("R6", 2);
        issue("R6_alu_taken_ignored", 0, 1, 0, 0, 0, 0, 0, 1, 0);
        expect_cur("R6", 1);

        // R7: multi-register and reserved classes
        issue("R7_load", 1, 1, 0, 0, 0, 0, 1, 0, 0);
        issue("R7_ldm", 4, 6, 1, 1, 1, 1, 1, 0, 0);
        expect_cur("R7", 6);
        issue("R7_after_ldm", 0, 1, 1, 1, 1, 1, 0, 0, 0);
        expect_cur("R7", 1);
        issue("R7_load", 1, 1, 0, 0, 0, 0, 2, 0, 0);
        issue("R7_stm", 5, 3, 1, 2, 1, 2, 0, 1, 0);
        issue("R7_code6", 6, 4, 1, 2, 1, 2, 0, 1, 0);
        expect_cur("R7", 4);

        // R1: mid-run reset clears a pending hazard
        issue("R1_load", 1, 1, 0, 0, 0, 0, 6, 0, 0);
        do_reset("R1_mid_reset");
        issue("R1_no_stall_after_reset", 0, 2, 1, 6, 1, 6, 0, 0, 0);
        expect_cur("R1", 2);

        // R8: long mixed stream on a narrow register range
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 9) == 0)
                idle("R9_rand_idle");
            else
                issue("R8_rand", $urandom_range(0, 7), $urandom_range(0, 255),
                      1'($urandom_range(0, 1)), $urandom_range(0, 3),
                      1'($urandom_range(0, 1)), $urandom_range(0, 3),
                      $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule